// File: doc/BRIEF.md
# Watchdog and Alarm Down Counter

This block is a down counter with a reloadable seed. A mode bit selects one of two jobs. As a repeating alarm it counts one step per slow (1 Hz) tick. On reaching zero it raises a sticky flag, reloads from the seed and keeps going. As a watchdog it counts one step per fast (4096 Hz) tick. On reaching zero it raises the flag and halts until software services it. Software services it by reading a seed byte or by raising the strobe input. Both tick enables come from outside the block.

Software reaches the block through a small byte-wide register bus. The bus holds the seed bytes, a control byte and a status byte. A seed of all zeros, or a cleared enable bit, turns the counter off. The seed bytes then act as plain storage. The interrupt output is a drive-low request: 1 pulls the shared line low and 0 leaves it floating. In alarm mode it follows the flag. In watchdog mode it emits a fixed pulse of 1024 fast ticks. This pulse cannot be cut short, and the flag clears itself when the pulse ends.

Top module: `wdt_alarm_counter`

## Requirements
- R1: After reset the seed, the control byte and the flag are all zero, and irqLow is 0.
- R2: While the enable bit (control bit 0) is 0, ticks never change the counter. The seed bytes at addresses 0..2 read back the values written to them.
- R3: While the committed seed is zero, the counter does not run even when the enable bit is 1.
- R4: Writes to seed bytes 0 and 1 are staged. Writing byte 2 (the most significant byte) commits all 24 bits at once. Reads of addresses 0..2 return the committed seed.
- R5: When a commit changes the seed from zero to nonzero, counting waits until the enable bit is written from 0 to 1. That write also loads the counter from the seed.
- R6: In alarm mode (control bit 1 = 0), the counter steps only on tick1Hz. The flag (status bit 0) sets on exactly the seed-th tick, the count reloads, and this repeats every seed ticks.
- R7: The flag is sticky. Writing 0 to status bit 0 clears it, and writing 1 has no effect.
- R8: In alarm mode, irqLow equals the flag while control bits 2 and 3 are both 1, and is 0 otherwise.
- R9: In watchdog mode (control bit 1 = 1), the counter steps only on tick4kHz. The flag sets on the seed-th tick, and the counter then stays at zero.
- R10: In watchdog mode, a bus read of any seed byte reloads the counter from the seed, and so does a rising edge on wdStrobe.
- R11: Committing a seed reloads the counter with the new value at once.
- R12: In watchdog mode with control bits 2 and 3 set, the tick that sets the flag starts a pulse. irqLow is 1 for the next 1023 ticks of tick4kHz. On the 1024th tick irqLow returns to 0 and the flag clears.
- R13: Clearing the flag or control bit 3 during the pulse does not shorten it.
- R14: A seed committed during the pulse is loaded, but the counter steps only after the pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle enable at the alarm rate |
| tick4kHz | input | 1 | One-cycle enable at the watchdog rate |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (side effect in watchdog mode) |
| busAddr | input | 3 | Register address: 0..2 seed bytes, 3 control, 4 status |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational on busAddr |
| wdStrobe | input | 1 | Watchdog service input; rising edge reloads |
| irqLow | output | 1 | 1 = drive interrupt line low, 0 = high impedance |

## Verification
A counter holding the wrong value shows up only as a flag that rises on the wrong tick. The bench therefore reads the status byte one tick before and on the tick where the seed predicts the terminal count, so an off-by-one appears within a single tick. A stuck run or stop state shows up as a missing flag, and a stale reload shows up as a flag that arrives too early. A wrong pulse counter shows on irqLow at tick 1023 or 1024 after the pulse starts. A leak of the pulse into counting shows as a flag one tick early after the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to the counter datapath
  typedef struct packed {
    logic load;  // take loadValue
    logic dec;   // step down by one
  } cntStrobe_t;

  localparam int CTL_EN  = 0;
  localparam int CTL_WD  = 1;
  localparam int CTL_INT = 2;
  localparam int CTL_IE  = 3;
  localparam int CTL_W   = 4;
endpackage

// File: rtl/wdt_count_dp.sv
module wdt_count_dp #(
  parameter int WIDTH = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdt_pkg::cntStrobe_t strobe,
  input  logic [WIDTH-1:0]    loadValue,
  output logic [WIDTH-1:0]    count,
  output logic                cntOne,
  output logic                cntZero
);
  always_ff @(posedge clk) begin
    if (!rstN)             count <= '0;
    else if (strobe.load)  count <= loadValue;
    else if (strobe.dec)   count <= count - 1'b1;
  end

  assign cntOne  = (count == WIDTH'(1));
  assign cntZero = (count == '0);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int WIDTH       = 24,
  parameter int PULSE_TICKS = 1024,
  parameter int ADDR_W      = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick1Hz,
  input  logic                     tick4kHz,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [7:0]               busWrData,
  output logic [7:0]               busRdData,
  input  logic                     wdStrobe,
  input  logic                     cntOne,
  input  logic                     cntZero,
  output wdt_pkg::cntStrobe_t      strobe,
  output logic [WIDTH-1:0]         loadValue,
  output logic [WIDTH-1:0]         seed,
  output logic [wdt_pkg::CTL_W-1:0] ctrlBits,
  output logic                     flag,
  output logic                     pulseActive,
  output logic                     irqLow
);
  import wdt_pkg::*;

  localparam int NBYTES = WIDTH / 8;
  localparam int PCW    = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(NBYTES - 1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NBYTES + 1);
  localparam logic [PCW-1:0]    PULSE_LAST = PCW'(PULSE_TICKS - 1);

  logic [WIDTH-9:0] stage;
  logic [PCW-1:0]   pulseCnt;
  logic             armWait;
  logic             wdsPrev;

  logic ctrlEn, wdMode, intSel, irqEn;
  assign ctrlEn = ctrlBits[CTL_EN];
  assign wdMode = ctrlBits[CTL_WD];
  assign intSel = ctrlBits[CTL_INT];
  assign irqEn  = ctrlBits[CTL_IE];

  logic seedRange, commit, rdSeed, wrCtrl, wrStat, enRise, wdsRise;
  logic reloadReq, running, tickSel, terminal, pulseStart, pulseEnd, clrFlag;
  logic [WIDTH-1:0] newSeed;

  always_comb begin
    seedRange = (busAddr <= TOP_ADDR);
    commit    = busWrEn && (busAddr == TOP_ADDR);
    rdSeed    = busRdEn && seedRange;
    wrCtrl    = busWrEn && (busAddr == CTRL_ADDR);
    wrStat    = busWrEn && (busAddr == STAT_ADDR);
    enRise    = wrCtrl && busWrData[CTL_EN] && !ctrlEn;
    wdsRise   = wdStrobe && !wdsPrev;
    newSeed   = {busWrData, stage};
    reloadReq = commit || enRise || (wdMode && (rdSeed || wdsRise));
    running   = ctrlEn && (seed != '0) && !armWait && !pulseActive && !cntZero;
    tickSel   = wdMode ? tick4kHz : tick1Hz;
    terminal  = running && tickSel && !reloadReq && cntOne;
    pulseStart = terminal && wdMode && intSel && irqEn;
    pulseEnd  = pulseActive && tick4kHz && (pulseCnt == PULSE_LAST);
    clrFlag   = wrStat && !busWrData[0] && !pulseActive;
  end

  // strobes and load source towards the datapath
  always_comb begin
    strobe.load = reloadReq || (terminal && !wdMode);
    strobe.dec  = running && tickSel && !reloadReq;
    loadValue   = commit ? newSeed : seed;
  end

  // seed staging and commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage <= '0;
      seed  <= '0;
    end else if (busWrEn) begin
      for (int i = 0; i < NBYTES - 1; i++)
        if (busAddr == ADDR_W'(i)) stage[i*8 +: 8] <= busWrData;
      if (commit) seed <= newSeed;
    end
  end

  // control byte, arm gate, strobe edge detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= '0;
      armWait  <= 1'b0;
      wdsPrev  <= 1'b0;
    end else begin
      wdsPrev <= wdStrobe;
      if (wrCtrl) ctrlBits <= busWrData[CTL_W-1:0];
      if (commit && (seed == '0) && (newSeed != '0)) armWait <= 1'b1;
      else if (enRise)                                armWait <= 1'b0;
    end
  end

  // flag and watchdog pulse timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag        <= 1'b0;
      pulseActive <= 1'b0;
      pulseCnt    <= '0;
    end else begin
      if (terminal)                 flag <= 1'b1;
      else if (pulseEnd || clrFlag) flag <= 1'b0;

      if (pulseStart) begin
        pulseActive <= 1'b1;
        pulseCnt    <= '0;
      end else if (pulseActive && tick4kHz) begin
        if (pulseEnd) pulseActive <= 1'b0;
        else          pulseCnt    <= pulseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = 8'h00;
    for (int i = 0; i < NBYTES; i++)
      if (busAddr == ADDR_W'(i)) busRdData = seed[i*8 +: 8];
    if (busAddr == CTRL_ADDR) busRdData = 8'(ctrlBits);
    if (busAddr == STAT_ADDR) busRdData = {7'b0, flag};
  end

  assign irqLow = pulseActive || (!wdMode && flag && intSel && irqEn);
endmodule

// File: rtl/wdt_alarm_counter.sv
module wdt_alarm_counter #(
  parameter int WIDTH       = 24,
  parameter int PULSE_TICKS = 1024,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  logic              tick4kHz,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              wdStrobe,
  output logic              irqLow
);
  wdt_pkg::cntStrobe_t             strobe;
  logic [WIDTH-1:0]                loadValue;
  logic [WIDTH-1:0]                seed;
  logic [WIDTH-1:0]                count;
  logic [wdt_pkg::CTL_W-1:0]       ctrlBits;
  logic                            flag;
  logic                            pulseActive;
  logic                            cntOne;
  logic                            cntZero;

  wdt_ctrl #(.WIDTH(WIDTH), .PULSE_TICKS(PULSE_TICKS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .tick4kHz(tick4kHz),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .wdStrobe(wdStrobe),
    .cntOne(cntOne), .cntZero(cntZero), .strobe(strobe),
    .loadValue(loadValue), .seed(seed), .ctrlBits(ctrlBits),
    .flag(flag), .pulseActive(pulseActive), .irqLow(irqLow)
  );

  wdt_count_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(loadValue),
    .count(count), .cntOne(cntOne), .cntZero(cntZero)
  );
endmodule

// File: rtl/wdt_alarm_counter_chk.sv
module wdt_alarm_counter_chk #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick4kHz,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic             wdStrobe,
  input logic             irqLow,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] seed,
  input logic [3:0]       ctrlBits,
  input logic             flag,
  input logic             pulseActive
);
  logic quiet;
  assign quiet = !busWrEn && !busRdEn && !wdStrobe;

  // R13
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive && !tick4kHz |=> pulseActive);
  // R12
  pulse_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive |-> irqLow);
  // R12
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseActive) |-> !flag);
  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[0] && quiet |=> $stable(count));
  // R3
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seed == '0) && quiet |=> $stable(count));
  // R9
  wd_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBits[1] && (count == '0) && quiet |=> (count == '0));
  // R8
  alarm_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[1] && flag && ctrlBits[2] && ctrlBits[3] |-> irqLow);
  // R14
  pulse_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive && quiet |=> $stable(count));
endmodule

bind wdt_alarm_counter wdt_alarm_counter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .tick4kHz(tick4kHz), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .wdStrobe(wdStrobe), .irqLow(irqLow), .count(count),
  .seed(seed), .ctrlBits(ctrlBits), .flag(flag), .pulseActive(pulseActive)
);

// File: tb/wdt_alarm_counter_tb_top.sv
module wdt_alarm_counter_tb_top;
  localparam int PULSE = 1024;
  localparam logic [7:0] EN = 8'h01, WD = 8'h02, INTS = 8'h04, IE = 8'h08;

  logic clk = 0, rstN = 0, tick1Hz = 0, tick4kHz = 0;
  logic busWrEn = 0, busRdEn = 0, wdStrobe = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWrData = 0, busRdData;
  logic irqLow;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdt_alarm_counter dut_i (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .tick4kHz(tick4kHz),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .wdStrobe(wdStrobe),
    .irqLow(irqLow)
  );

  function automatic int flagTick(int s); return s; endfunction
  function automatic int pulseTicks(); return PULSE; endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rdByte(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1; #1 d = busRdData;
    @(negedge clk); busRdEn = 0;
  endtask

  task automatic setSeed(input int v);
    wr(0, v[7:0]); wr(1, v[15:8]); wr(2, v[23:16]);
  endtask

  task automatic tickA(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick1Hz = 1; @(negedge clk); tick1Hz = 0;
    end
  endtask

  task automatic tickW(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick4kHz = 1; @(negedge clk); tick4kHz = 0;
    end
  endtask

  task automatic wdsPulse();
    @(negedge clk); wdStrobe = 1; @(negedge clk); wdStrobe = 0;
  endtask

  task automatic expFlag(input bit e, input string req);
    busAddr = 3'd4; #1;
    check(busRdData[0] == e, req, busRdData[0], e);
  endtask

  task automatic expIrq(input bit e, input string req);
    #1 check(irqLow == e, req, irqLow, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    expFlag(0, "R1 flag"); expIrq(0, "R1 irq");
    rdByte(0, d); check(d == 0, "R1 seed0", d, 0);
    busAddr = 3'd3; #1 check(busRdData == 0, "R1 ctrl", busRdData, 0);

    // R4 staging, R2 storage with enable off
    wr(0, 8'h12); wr(1, 8'h34);
    rdByte(0, d); check(d == 8'h00, "R4 staged byte0", d, 0);
    wr(2, 8'h00);
    rdByte(0, d); check(d == 8'h12, "R4 byte0", d, 8'h12);
    rdByte(1, d); check(d == 8'h34, "R2 R4 byte1", d, 8'h34);
    tickA(60); tickW(60);
    expFlag(0, "R2 no count when disabled");

    // R3 zero seed disables
    setSeed(0); wr(3, EN);
    tickA(20);
    expFlag(0, "R3 zero seed");

    // R5 zero to nonzero needs enable rise
    setSeed(3);
    tickA(10);
    expFlag(0, "R5 waits for enable rise");
    wr(3, 8'h00); wr(3, EN | INTS | IE);

    // R6 alarm terminal, R8 irq follows flag
    tickA(2); expFlag(0, "R6 before terminal"); expIrq(0, "R8 idle");
    tickW(10); expFlag(0, "R6 fast tick ignored");
    tickA(1); expFlag(1, "R6 terminal"); expIrq(1, "R8 irq active");
    // R7 sticky flag
    wr(4, 8'h01); expFlag(1, "R7 write one keeps flag");
    wr(4, 8'h00); expFlag(0, "R7 clear"); expIrq(0, "R8 released");
    tickA(2); expFlag(0, "R6 repeat early");
    tickA(1); expFlag(1, "R6 repeat");
    wr(3, EN); expIrq(0, "R8 masked");
    wr(3, EN | INTS | IE); wr(4, 8'h00);

    // random alarm runs, R11 commit reloads mid-count
    for (int k = 0; k < 6; k++) begin
      int s;
      s = $urandom_range(1, 40);
      tickA($urandom_range(0, 3));
      setSeed(s); wr(4, 8'h00);
      if (flagTick(s) > 1) begin
        tickA(flagTick(s) - 1); expFlag(0, "R11 R6 random early");
      end
      tickA(1); expFlag(1, "R11 R6 random terminal");
      wr(4, 8'h00);
    end

    // R9 watchdog
    wr(3, EN | WD); setSeed(5); wr(4, 8'h00);
    tickW(4); expFlag(0, "R9 early");
    tickA(10); expFlag(0, "R9 slow tick ignored");
    tickW(1); expFlag(1, "R9 terminal");
    wr(4, 8'h00); tickW(20); expFlag(0, "R9 stopped");

    // R10 reload by read and by strobe edge
    rdByte(0, d); tickW(4); rdByte(1, d); tickW(4);
    expFlag(0, "R10 read reload");
    tickW(1); expFlag(1, "R10 terminal after read");
    wr(4, 8'h00);
    wdsPulse(); tickW(4); wdsPulse(); tickW(4);
    expFlag(0, "R10 strobe reload");
    tickW(1); expFlag(1, "R10 terminal after strobe");
    wr(4, 8'h00);

    // random watchdog runs
    for (int k = 0; k < 4; k++) begin
      int s;
      s = $urandom_range(1, 30);
      setSeed(s); wr(4, 8'h00);
      if ($urandom_range(0, 1) == 1) wdsPulse(); else rdByte(2, d);
      if (flagTick(s) > 1) begin
        tickW(flagTick(s) - 1); expFlag(0, "R10 random early");
      end
      tickW(1); expFlag(1, "R9 random terminal");
      wr(4, 8'h00);
    end

    // R12 pulse, R13 not truncated, R14 deferred counting
    setSeed(5); wr(3, EN | WD | INTS | IE); wdsPulse();
    tickW(5); expFlag(1, "R12 flag"); expIrq(1, "R12 pulse start");
    wr(4, 8'h00); wr(3, EN | WD | INTS);
    setSeed(2);
    expFlag(1, "R13 flag kept"); expIrq(1, "R13 pulse kept");
    tickW(pulseTicks() - 1);
    expIrq(1, "R12 pulse last tick"); expFlag(1, "R12 flag during pulse");
    tickW(1);
    expIrq(0, "R12 pulse end"); expFlag(0, "R12 self clear");
    tickW(1); expFlag(0, "R14 count held during pulse");
    tickW(1); expFlag(1, "R14 terminal after pulse"); expIrq(0, "R12 no pulse");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule